// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer load, inspect and wipe two small on-chip memories over a three-wire synchronous serial link. The first memory is a program store of 16-bit words, and the second is a data store of bytes. The programmer drives a serial clock and a data line into the slave, and the slave returns data on its own output line. Each transaction is a fixed frame of four bytes.

The link is live only while the active-low `progRstN` input is held low. When `progRstN` is high, the block is held in its idle state: half-received frames are dropped and the enable flag is cleared. Both memories keep their contents through this idle state. Once the programmer enters programming mode, it must first send an enable frame. The slave proves that it is in step by echoing one byte of that frame back. Until enable succeeds, every other frame has no effect.

The serial clock is never used as a clock inside the block. It is passed through a synchroniser running on the system clock, and its edges are found there. Writes and chip erase each start a self-timed busy window. The programmer can observe this window through a poll frame. The memories are plain register arrays and have no non-volatile behaviour.

Top module: `isp_slave`

## Requirements
- R1: While `progRstN` is high, `miso` is 0, no frame has any effect on either memory, and the enabled state is held clear.
- R2: After `progRstN` goes low, only the enable frame `AC 53 xx xx` is honoured. Any other frame before it changes no memory and returns 0 in all four response bytes.
- R3: During the third byte of an enable frame, the slave shifts out the second byte it received (0x53). The other response bytes of that frame are 0.
- R4: Chip erase is the frame `AC 80 xx xx`. It sets every word of the program store to 0xFFFF and every byte of the data store to 0xFF.
- R5: Program writes use `40 hh ll dd` for the low byte and `48 hh ll dd` for the high byte of a word. Each write stores the old byte AND `dd`, so bits can only be cleared until the next erase. The other byte of the word is unchanged.
- R6: The data write `C0 hh ll dd` replaces the addressed byte with `dd` whatever its old value, with no prior erase.
- R7: The read frames are `20 hh ll xx` (program low byte), `28 hh ll xx` (program high byte) and `A0 hh ll xx` (data byte). Each returns the addressed value in the fourth response byte. The address is the low log2(depth) bits of {hh,ll}, and the upper bits are ignored.
- R8: Every accepted write or erase makes the block busy for exactly `BUSY_CYCLES` system clocks. The poll frame `F0 xx xx xx` returns 0x01 in its fourth byte while the block is busy and 0x00 otherwise.
- R9: Write and erase frames whose last byte completes while the block is busy are dropped. Read and poll frames are still served during the busy window.
- R10: Raising `progRstN` discards any partly received frame and clears the enabled state. After re-entry, frames align to the first bit sent and enable is needed again.
- R11: Bytes are sent MSB first. `mosi` is sampled on the rising edge of `sck`, and `miso` changes after the falling edge. Each `sck` high phase and each `sck` low phase of at least four system clocks is recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial lines |
| progRstN | input | 1 | Active low: programming mode while low, idle and cleared while high |
| sck | input | 1 | Serial clock from the programmer, must be low on entering programming mode |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |

## Verification
A wrong bit or byte counter shows up as misaligned response bytes: the 0x53 echo appears in the wrong byte position of the very next enable frame. A stale enabled flag or a stuck busy counter shows up at the ports within one or two frames, as a read or poll returning a nonzero byte where 0 is due, or as a write that either lands or vanishes when the opposite is expected. Errors in memory contents, such as a missing AND on program writes or an erase that skips an address, only become visible when that address is read back. For this reason the directed scenarios read both boundary addresses and rewrite the same locations.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int BYTE_W      = 8;
  localparam int BIT_IDX_W   = $clog2(BYTE_W);
  localparam int FRAME_BYTES = 4;
  localparam int BYTE_IDX_W  = $clog2(FRAME_BYTES);

  // command bytes
  localparam logic [BYTE_W-1:0] OP_PREFIX   = 8'hAC;
  localparam logic [BYTE_W-1:0] SUB_ENABLE  = 8'h53;
  localparam logic [BYTE_W-1:0] SUB_ERASE   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_POLL     = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_RD_PLO   = 8'h20;
  localparam logic [BYTE_W-1:0] OP_RD_PHI   = 8'h28;
  localparam logic [BYTE_W-1:0] OP_WR_PLO   = 8'h40;
  localparam logic [BYTE_W-1:0] OP_WR_PHI   = 8'h48;
  localparam logic [BYTE_W-1:0] OP_RD_DATA  = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_WR_DATA  = 8'hC0;

  typedef enum logic [2:0] {
    OUT_KEEP,
    OUT_ZERO,
    OUT_ECHO,
    OUT_READ,
    OUT_POLL
  } out_sel_e;

  typedef struct packed {
    logic                  shiftIn;
    logic                  shiftOut;
    logic [BIT_IDX_W-1:0]  bitIdx;
    logic                  storeByte;
    logic [BYTE_IDX_W-1:0] byteIdx;
    out_sel_e              outSel;
    logic                  wrProgLo;
    logic                  wrProgHi;
    logic                  wrData;
    logic                  eraseAll;
    logic                  busy;
  } isp_strobe_t;

endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic sckIn,
  input  logic mosiIn,
  output logic sckRise,
  output logic sckFall,
  output logic mosiBit
);

  logic [STAGES-1:0] sckPipe;
  logic [STAGES-1:0] mosiPipe;
  logic              sckLast;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      sckPipe[0]  <= 1'b0;
      mosiPipe[0] <= 1'b0;
    end else begin
      sckPipe[0]  <= sckIn;
      mosiPipe[0] <= mosiIn;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
        sckPipe[s]  <= 1'b0;
        mosiPipe[s] <= 1'b0;
      end else begin
        sckPipe[s]  <= sckPipe[s-1];
        mosiPipe[s] <= mosiPipe[s-1];
      end
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) sckLast <= 1'b0;
    else     sckLast <= sckPipe[STAGES-1];
  end

  assign sckRise = sckPipe[STAGES-1] & ~sckLast;
  assign sckFall = ~sckPipe[STAGES-1] & sckLast;
  assign mosiBit = mosiPipe[STAGES-1];

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic [BYTE_W-1:0] frameB0,
  input  logic [BYTE_W-1:0] frameB1,
  input  logic [BYTE_W-1:0] nextByte,
  output isp_strobe_t       st,
  output logic              enabled
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BIT_IDX_W-1:0]  LAST_BIT  = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(FRAME_BYTES - 1);

  logic [BIT_IDX_W-1:0]  bitCnt;
  logic [BYTE_IDX_W-1:0] byteCnt;
  logic [BUSY_W-1:0]     busyCnt;
  logic                  busy;
  logic                  lastBit;
  logic                  execNow;
  logic                  isEnable;
  logic                  isRead;
  logic                  startBusy;

  assign busy     = (busyCnt != '0);
  assign lastBit  = sckRise && (bitCnt == LAST_BIT);
  assign execNow  = lastBit && (byteCnt == LAST_BYTE);
  assign isEnable = (frameB0 == OP_PREFIX) && (frameB1 == SUB_ENABLE);
  assign isRead   = (frameB0 == OP_RD_PLO) || (frameB0 == OP_RD_PHI) ||
                    (frameB0 == OP_RD_DATA);

  always_comb begin
    st           = '0;
    st.outSel    = OUT_KEEP;
    st.shiftIn   = sckRise;
    st.shiftOut  = sckFall;
    st.bitIdx    = bitCnt;
    st.byteIdx   = byteCnt;
    st.storeByte = lastBit && (byteCnt != LAST_BYTE);
    st.busy      = busy;
    if (lastBit) begin
      unique case (byteCnt)
        2'd1: st.outSel = ((frameB0 == OP_PREFIX) && (nextByte == SUB_ENABLE))
                          ? OUT_ECHO : OUT_ZERO;
        2'd2: begin
          if (enabled && isRead)                  st.outSel = OUT_READ;
          else if (enabled && frameB0 == OP_POLL) st.outSel = OUT_POLL;
          else                                    st.outSel = OUT_ZERO;
        end
        default: st.outSel = OUT_ZERO;
      endcase
    end
    if (execNow && enabled && !busy) begin
      st.eraseAll = (frameB0 == OP_PREFIX) && (frameB1 == SUB_ERASE);
      st.wrProgLo = (frameB0 == OP_WR_PLO);
      st.wrProgHi = (frameB0 == OP_WR_PHI);
      st.wrData   = (frameB0 == OP_WR_DATA);
    end
  end

  assign startBusy = st.eraseAll | st.wrProgLo | st.wrProgHi | st.wrData;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      enabled <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (sckRise) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) byteCnt <= byteCnt + 1'b1;
      end
      if (execNow && isEnable) enabled <= 1'b1;
      if (startBusy)  busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy)  busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int PROG_WORDS = 64,
  parameter int DATA_BYTES = 32
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              mosiBit,
  input  isp_strobe_t       st,
  output logic [BYTE_W-1:0] frameB0,
  output logic [BYTE_W-1:0] frameB1,
  output logic [BYTE_W-1:0] nextByte,
  output logic              miso
);

  localparam int PROG_AW = $clog2(PROG_WORDS);
  localparam int DATA_AW = $clog2(DATA_BYTES);
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int HELD    = FRAME_BYTES - 1;

  logic [BYTE_W-2:0]  shiftQ;
  logic [BYTE_W-1:0]  frameQ [HELD];
  logic [BYTE_W-1:0]  outByte;
  logic [BYTE_W-1:0]  readVal;
  logic               misoQ;
  logic [WORD_W-1:0]  progMem [PROG_WORDS];
  logic [BYTE_W-1:0]  dataMem [DATA_BYTES];
  logic [PROG_AW-1:0] progRdIdx;
  logic [PROG_AW-1:0] progWrIdx;
  logic [DATA_AW-1:0] dataRdIdx;
  logic [DATA_AW-1:0] dataWrIdx;

  assign nextByte = {shiftQ, mosiBit};
  assign frameB0  = frameQ[0];
  assign frameB1  = frameQ[1];

  // read address completes with the third byte, write address is held
  assign progRdIdx = PROG_AW'({frameQ[1], nextByte});
  assign dataRdIdx = DATA_AW'({frameQ[1], nextByte});
  assign progWrIdx = PROG_AW'({frameQ[1], frameQ[2]});
  assign dataWrIdx = DATA_AW'({frameQ[1], frameQ[2]});

  always_comb begin
    unique case (frameQ[0])
      OP_RD_PLO:  readVal = progMem[progRdIdx][BYTE_W-1:0];
      OP_RD_PHI:  readVal = progMem[progRdIdx][WORD_W-1:BYTE_W];
      OP_RD_DATA: readVal = dataMem[dataRdIdx];
      default:    readVal = '0;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      shiftQ  <= '0;
      outByte <= '0;
      misoQ   <= 1'b0;
      for (int i = 0; i < HELD; i++) frameQ[i] <= '0;
    end else begin
      if (st.shiftIn) shiftQ <= nextByte[BYTE_W-2:0];
      if (st.storeByte) frameQ[st.byteIdx] <= nextByte;
      unique case (st.outSel)
        OUT_ZERO: outByte <= '0;
        OUT_ECHO: outByte <= nextByte;
        OUT_READ: outByte <= readVal;
        OUT_POLL: outByte <= {{(BYTE_W-1){1'b0}}, st.busy};
        default:  outByte <= outByte;
      endcase
      if (st.shiftOut) misoQ <= outByte[BIT_IDX_W'(BYTE_W - 1) - st.bitIdx];
    end
  end

  // storage is kept across programming sessions
  always_ff @(posedge clk) begin
    if (st.eraseAll) begin
      for (int w = 0; w < PROG_WORDS; w++) progMem[w] <= '1;
      for (int b = 0; b < DATA_BYTES; b++) dataMem[b] <= '1;
    end else begin
      if (st.wrProgLo)
        progMem[progWrIdx][BYTE_W-1:0] <= progMem[progWrIdx][BYTE_W-1:0] & nextByte;
      if (st.wrProgHi)
        progMem[progWrIdx][WORD_W-1:BYTE_W] <= progMem[progWrIdx][WORD_W-1:BYTE_W] & nextByte;
      if (st.wrData)
        dataMem[dataWrIdx] <= nextByte;
    end
  end

  assign miso = misoQ;

endmodule

// File: rtl/isp_slave.sv
module isp_slave
  import isp_pkg::*;
#(
  parameter int PROG_WORDS  = 64,
  parameter int DATA_BYTES  = 32,
  parameter int BUSY_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic progRstN,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  logic              sckRise;
  logic              sckFall;
  logic              mosiBit;
  logic              enabledQ;
  logic [BYTE_W-1:0] frameB0;
  logic [BYTE_W-1:0] frameB1;
  logic [BYTE_W-1:0] nextByte;
  isp_strobe_t       strobes;

  isp_sck_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .clr     (progRstN),
    .sckIn   (sck),
    .mosiIn  (mosi),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .mosiBit (mosiBit)
  );

  isp_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) i_ctrl (
    .clk      (clk),
    .clr      (progRstN),
    .sckRise  (sckRise),
    .sckFall  (sckFall),
    .frameB0  (frameB0),
    .frameB1  (frameB1),
    .nextByte (nextByte),
    .st       (strobes),
    .enabled  (enabledQ)
  );

  isp_datapath #(.PROG_WORDS(PROG_WORDS), .DATA_BYTES(DATA_BYTES)) i_dp (
    .clk      (clk),
    .clr      (progRstN),
    .mosiBit  (mosiBit),
    .st       (strobes),
    .frameB0  (frameB0),
    .frameB1  (frameB1),
    .nextByte (nextByte),
    .miso     (miso)
  );

endmodule

// File: rtl/isp_slave_chk.sv
module isp_slave_chk
  import isp_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input logic              clk,
  input logic              progRstN,
  input logic              miso,
  input logic              enabled,
  input logic              busy,
  input logic [3:0]        cmdStrobes,
  input logic [BYTE_W-1:0] frameB0,
  input logic [BYTE_W-1:0] frameB1
);

  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or posedge progRstN) begin
    if (progRstN)  busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R1
  idle_miso_low_chk: assert property (@(posedge clk)
    progRstN |=> !miso);

  // R2
  enable_needs_frame_chk: assert property (@(posedge clk) disable iff (progRstN)
    $rose(enabled) |-> (frameB0 == OP_PREFIX && frameB1 == SUB_ENABLE));

  // R2
  no_cmd_before_enable_chk: assert property (@(posedge clk) disable iff (progRstN)
    !enabled |-> (cmdStrobes == 4'b0000));

  // R8
  busy_after_cmd_chk: assert property (@(posedge clk) disable iff (progRstN)
    (|cmdStrobes) |=> busy);

  // R8
  busy_length_chk: assert property (@(posedge clk) disable iff (progRstN)
    $fell(busy) |-> (busyRun == RUN_W'(BUSY_CYCLES)));

  // R9
  no_cmd_while_busy_chk: assert property (@(posedge clk) disable iff (progRstN)
    busy |-> (cmdStrobes == 4'b0000));

  // R5
  single_cmd_chk: assert property (@(posedge clk) disable iff (progRstN)
    $onehot0(cmdStrobes));

endmodule

bind isp_slave isp_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_isp_slave_chk (
  .clk        (clk),
  .progRstN   (progRstN),
  .miso       (miso),
  .enabled    (enabledQ),
  .busy       (strobes.busy),
  .cmdStrobes ({strobes.wrProgLo, strobes.wrProgHi, strobes.wrData, strobes.eraseAll}),
  .frameB0    (frameB0),
  .frameB1    (frameB1)
);

// File: tb/test_isp_slave.sv
module test_isp_slave;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 400;
  localparam int HALF       = 5;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic progRstN;
  logic sck;
  logic mosi;
  logic miso;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  isp_slave #(.BUSY_CYCLES(BUSY)) i_isp_slave (
    .clk      (clk),
    .progRstN (progRstN),
    .sck      (sck),
    .mosi     (mosi),
    .miso     (miso)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, input int half, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (half) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (half) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3,
                       input int half, output logic [31:0] rsp);
    logic [7:0] r0, r1, r2, r3;
    xferByte(b0, half, r0);
    xferByte(b1, half, r1);
    xferByte(b2, half, r2);
    xferByte(b3, half, r3);
    rsp = {r0, r1, r2, r3};
  endtask

  task automatic waitIdle();
    repeat (BUSY + 40) @(negedge clk);
  endtask

  task automatic doEnable(input string req);
    logic [31:0] rsp;
    frame(8'hAC, 8'h53, 8'h00, 8'h00, HALF, rsp);
    check(req, "enable echo", rsp, 32'h0000_5300);
  endtask

  task automatic readByte(input logic [7:0] op, input logic [7:0] hi,
                          input logic [7:0] lo, input int half, output logic [7:0] val);
    logic [31:0] rsp;
    frame(op, hi, lo, 8'h00, half, rsp);
    val = rsp[7:0];
  endtask

  task automatic testResetState();
    repeat (5) @(negedge clk);
    check("R1", "miso while idle", {31'd0, miso}, 32'd0);
  endtask

  task automatic testInactive();
    logic [31:0] rsp;
    frame(8'hAC, 8'h53, 8'h00, 8'h00, HALF, rsp);
    check("R1", "enable response while idle", rsp, 32'd0);
  endtask

  task automatic testNoEnable();
    logic [31:0] rsp;
    frame(8'hA0, 8'h00, 8'h03, 8'h00, HALF, rsp);
    check("R2", "read before enable", rsp, 32'd0);
    frame(8'hF0, 8'h00, 8'h00, 8'h00, HALF, rsp);
    check("R2", "poll before enable", rsp, 32'd0);
  endtask

  task automatic testErase();
    logic [31:0] rsp;
    logic [7:0]  v;
    frame(8'hAC, 8'h80, 8'h00, 8'h00, HALF, rsp);
    waitIdle();
    readByte(8'h20, 8'h00, 8'h00, HALF, v); check("R4", "prog lo word 0", {24'd0, v}, 32'hFF);
    readByte(8'h28, 8'h00, 8'h3F, HALF, v); check("R4", "prog hi word 63", {24'd0, v}, 32'hFF);
    readByte(8'hA0, 8'h00, 8'h00, HALF, v); check("R4", "data byte 0", {24'd0, v}, 32'hFF);
    readByte(8'hA0, 8'h00, 8'h1F, HALF, v); check("R4", "data byte 31", {24'd0, v}, 32'hFF);
  endtask

  task automatic testProgWrite();
    logic [31:0] rsp;
    logic [7:0]  v;
    frame(8'h40, 8'h01, 8'h07, 8'h0F, HALF, rsp);
    waitIdle();
    readByte(8'h20, 8'h00, 8'h07, HALF, v); check("R7", "prog lo aliased addr", {24'd0, v}, 32'h0F);
    frame(8'h40, 8'h00, 8'h07, 8'hF3, HALF, rsp);
    waitIdle();
    readByte(8'h20, 8'h00, 8'h07, HALF, v); check("R5", "prog lo AND", {24'd0, v}, 32'h03);
    readByte(8'h28, 8'h00, 8'h07, HALF, v); check("R5", "prog hi untouched", {24'd0, v}, 32'hFF);
    frame(8'h48, 8'h00, 8'h07, 8'h5A, HALF, rsp);
    waitIdle();
    readByte(8'h28, 8'h00, 8'h07, HALF, v); check("R5", "prog hi write", {24'd0, v}, 32'h5A);
    readByte(8'h20, 8'h00, 8'h08, HALF, v); check("R7", "prog neighbour", {24'd0, v}, 32'hFF);
  endtask

  task automatic testDataWrite();
    logic [31:0] rsp;
    logic [7:0]  v;
    frame(8'hC0, 8'h00, 8'h05, 8'h0F, HALF, rsp);
    waitIdle();
    frame(8'hC0, 8'h00, 8'h05, 8'hF3, HALF, rsp);
    waitIdle();
    readByte(8'hA0, 8'h00, 8'h05, HALF, v); check("R6", "data overwrite", {24'd0, v}, 32'hF3);
    readByte(8'hA0, 8'hFF, 8'h25, HALF, v); check("R7", "data aliased addr", {24'd0, v}, 32'hF3);
  endtask

  task automatic testPoll();
    logic [31:0] rsp;
    frame(8'hC0, 8'h00, 8'h09, 8'h5A, HALF, rsp);
    frame(8'hF0, 8'h00, 8'h00, 8'h00, HALF, rsp);
    check("R8", "poll while busy", rsp, 32'h0000_0001);
    waitIdle();
    frame(8'hF0, 8'h00, 8'h00, 8'h00, HALF, rsp);
    check("R8", "poll when idle", rsp, 32'd0);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] rsp;
    logic [7:0]  v;
    frame(8'hC0, 8'h00, 8'h0A, 8'h11, HALF, rsp);
    frame(8'hC0, 8'h00, 8'h0A, 8'h22, HALF, rsp);
    readByte(8'hA0, 8'h00, 8'h09, HALF, v); check("R9", "read during busy", {24'd0, v}, 32'h5A);
    waitIdle();
    readByte(8'hA0, 8'h00, 8'h0A, HALF, v); check("R9", "write while busy dropped", {24'd0, v}, 32'h11);
  endtask

  task automatic testRelease();
    logic [31:0] rsp;
    logic [7:0]  r;
    logic [7:0]  v;
    xferByte(8'hC0, HALF, r);
    xferByte(8'h00, HALF, r);
    progRstN = 1'b1;
    repeat (5) @(negedge clk);
    progRstN = 1'b0;
    repeat (5) @(negedge clk);
    frame(8'hC0, 8'h00, 8'h0A, 8'h77, HALF, rsp);
    waitIdle();
    doEnable("R10");
    readByte(8'hA0, 8'h00, 8'h0A, HALF, v); check("R10", "write after release dropped", {24'd0, v}, 32'h11);
  endtask

  task automatic testIdleWrite();
    logic [31:0] rsp;
    logic [7:0]  v;
    progRstN = 1'b1;
    repeat (3) @(negedge clk);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, HALF, rsp);
    frame(8'hC0, 8'h00, 8'h0A, 8'h99, HALF, rsp);
    check("R1", "write response while idle", rsp, 32'd0);
    progRstN = 1'b0;
    repeat (5) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h0A, 8'h00, HALF, rsp);
    check("R1", "enable cleared while idle", rsp, 32'd0);
    doEnable("R1");
    readByte(8'hA0, 8'h00, 8'h0A, HALF, v); check("R1", "idle write ignored", {24'd0, v}, 32'h11);
  endtask

  task automatic testFastSck();
    logic [31:0] rsp;
    logic [7:0]  v;
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 4, rsp);
    check("R11", "echo at 4-clock phases", rsp, 32'h0000_5300);
    readByte(8'h28, 8'h00, 8'h07, 4, v); check("R11", "read at 4-clock phases", {24'd0, v}, 32'h5A);
  endtask

  initial begin
    progRstN = 1'b1;
    sck      = 1'b0;
    mosi     = 1'b0;
    testResetState();
    testInactive();
    progRstN = 1'b0;
    repeat (5) @(negedge clk);
    testNoEnable();
    doEnable("R3");
    testErase();
    testProgWrite();
    testDataWrite();
    testPoll();
    testBusyIgnore();
    testRelease();
    testIdleWrite();
    testFastSck();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule